// File: doc/BRIEF.md
# Serial Divider-Setting Receiver

This block takes divider settings for a frequency synthesiser over three slow serial lines: a shift clock, a data line and a load strobe. All three lines are asynchronous to the block's system clock, so each one passes through a two-flop synchroniser. Edges are then detected in the system-clock domain.

While the load strobe is low, each rising edge of the shift clock moves one data bit into a 19-bit shift register, most significant bit first. The sender changes data on falling shift-clock edges. When the load strobe rises, the last bit received decides which latch receives the word:

- **Feedback latch.** This holds the 11-bit main count and the 7-bit swallow count.
- **Reference latch.** This holds four control flags (cs, lds, fc, sw) and the 14-bit reference divide value.

Each latch gives a one-cycle update strobe when it takes a new word. Two kinds of word are refused:

- A word that arrives with too few bits is dropped, and a framing flag is raised.
- A reference word whose divide value is below 3 is refused, and the latch keeps its old contents.

A three-state machine controls the transfer:

- **ST_COLLECT** shifts bits in. It moves to ST_DECIDE on a synchronised rising edge of the load strobe.
- **ST_DECIDE** judges the captured word and updates at most one latch. It always moves to ST_WAIT_LOW on the next cycle.
- **ST_WAIT_LOW** ignores the shift clock. It returns to ST_COLLECT once the synchronised load strobe is low.

Top module: `serial_div_prog`

## Requirements
- R1: After reset, div_a and div_b are 0, ref_div is 3, the four control flags are 0, and n_upd, r_upd and frame_err are 0.
- R2: A word w[18:0] is captured MSB first on rising ser_clk edges. With w[0]=0 and all 19 bits present, the rising edge of ser_le loads div_b=w[18:8] and div_a=w[7:1], and n_upd pulses.
- R3: With w[0]=1, the rising edge of ser_le loads ctl_cs=w[18], ctl_lds=w[17], ctl_fc=w[16], ctl_sw=w[15] and ref_div=w[14:1], and r_upd pulses.
- R4: n_upd and r_upd each last exactly one cycle and are never high together. A feedback transfer leaves the reference latch and flags unchanged, and a reference transfer leaves div_a and div_b unchanged.
- R5: A reference word with divide value 0, 1 or 2 gives no strobe, and ref_div and the control flags keep their previous values.
- R6: Reference divide values of 3 and 16383 are accepted.
- R7: A rising edge of ser_le after fewer than 19 shifted bits changes no latch, gives no strobe and sets frame_err. frame_err stays set until the next accepted transfer clears it.
- R8: If more than 19 bits are shifted in before ser_le rises, only the last 19 bits form the word.
- R9: Edges of ser_clk while ser_le is high are not shifted or counted. Bit counting restarts from zero after ser_le falls.
- R10: The strobe, the new latch values and the frame_err change all appear on the fourth rising sys_clk edge after ser_le rises at the pin, with ser_le changed between sys_clk edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; rising edge transfers the word |
| div_a | output | 7 | Latched swallow count |
| div_b | output | 11 | Latched main count |
| ref_div | output | 14 | Latched reference divide value |
| ctl_cs | output | 1 | Latched control flag cs |
| ctl_lds | output | 1 | Latched control flag lds |
| ctl_fc | output | 1 | Latched control flag fc |
| ctl_sw | output | 1 | Latched control flag sw |
| n_upd | output | 1 | One-cycle strobe on a feedback latch update |
| r_upd | output | 1 | One-cycle strobe on a reference latch update |
| frame_err | output | 1 | Set by a short word, cleared by an accepted transfer |

## Verification
Every result of this block depends on the load strobe. Two synchroniser flops, the edge register and the ST_DECIDE cycle put each strobe, latch change and framing-flag change on the fourth sys_clk edge after ser_le rises.

The bench drives all pins on falling sys_clk edges and reads outputs on falling edges. It checks the strobe is low after the third edge and high after the fourth. A scoreboard monitor compares latch contents whenever a strobe appears. Refused and short words are judged only after the full load pulse and its recovery time have passed.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT  = 2'd0,
        ST_DECIDE   = 2'd1,
        ST_WAIT_LOW = 2'd2
    } sdp_state_t;

endpackage

// File: rtl/sdp_sync.sv
module sdp_sync #(
    parameter int LINES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d_async,
    output logic [LINES-1:0] d_sync
);

    // Two-flop synchroniser, one chain per line.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic meta_q;
        logic sync_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d_async[g];
                sync_q <= meta_q;
            end
        end

        assign d_sync[g] = sync_q;
    end

endmodule

// File: rtl/sdp_shifter.sv
module sdp_shifter #(
    parameter int WORD_W = 19,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              cnt_clr,
    output logic [WORD_W-1:0] word,
    output logic              full
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[WORD_W-2:0], bit_in};
        end
    end

    // The bit count saturates, so a long word keeps its last WORD_W bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_clr) begin
            cnt_q <= '0;
        end else if (shift_en && (cnt_q != CNT_FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign full = (cnt_q == CNT_FULL);

endmodule

// File: rtl/sdp_fsm.sv
module sdp_fsm
    import sdp_pkg::*;
#(
    parameter int A_W    = 7,
    parameter int B_W    = 11,
    parameter int CTL_W  = 4,
    parameter int R_W    = 14,
    parameter int R_MIN  = 3,
    parameter int WORD_W = A_W + B_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le_rise,
    input  logic              le_lvl,
    input  logic [WORD_W-1:0] word,
    input  logic              full,
    output sdp_state_t        state,
    output logic [A_W-1:0]    a_q,
    output logic [B_W-1:0]    b_q,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [R_W-1:0]    r_q,
    output logic              n_stb,
    output logic              r_stb,
    output logic              ferr_q
);

    localparam logic [R_W-1:0] R_FLOOR = R_W'(R_MIN);

    sdp_state_t state_d;

    // Word fields; bit 0 is the latch select.
    logic             sel_ref;
    logic [A_W-1:0]   w_a;
    logic [B_W-1:0]   w_b;
    logic [CTL_W-1:0] w_ctl;
    logic [R_W-1:0]   w_r;

    assign sel_ref = word[0];
    assign w_a     = word[A_W:1];
    assign w_b     = word[A_W+B_W:A_W+1];
    assign w_r     = word[R_W:1];
    assign w_ctl   = word[R_W+CTL_W:R_W+1];

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_COLLECT;
        end else begin
            state <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_COLLECT:  if (le_rise) state_d = ST_DECIDE;
            ST_DECIDE:   state_d = ST_WAIT_LOW;
            ST_WAIT_LOW: if (!le_lvl) state_d = ST_COLLECT;
            default:     state_d = ST_COLLECT;
        endcase
    end

    // Outputs and latches.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            ctl_q  <= '0;
            r_q    <= R_FLOOR;
            n_stb  <= 1'b0;
            r_stb  <= 1'b0;
            ferr_q <= 1'b0;
        end else begin
            n_stb <= 1'b0;
            r_stb <= 1'b0;
            unique case (state)
                ST_DECIDE: begin
                    if (!full) begin
                        ferr_q <= 1'b1;
                    end else if (!sel_ref) begin
                        a_q    <= w_a;
                        b_q    <= w_b;
                        n_stb  <= 1'b1;
                        ferr_q <= 1'b0;
                    end else if (w_r >= R_FLOOR) begin
                        ctl_q  <= w_ctl;
                        r_q    <= w_r;
                        r_stb  <= 1'b1;
                        ferr_q <= 1'b0;
                    end
                end
                ST_COLLECT, ST_WAIT_LOW: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/serial_div_prog.sv
module serial_div_prog
    import sdp_pkg::*;
#(
    parameter int A_W   = 7,
    parameter int B_W   = 11,
    parameter int CTL_W = 4,
    parameter int R_W   = 14,
    parameter int R_MIN = 3
) (
    input  logic           sys_clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_le,
    output logic [A_W-1:0] div_a,
    output logic [B_W-1:0] div_b,
    output logic [R_W-1:0] ref_div,
    output logic           ctl_cs,
    output logic           ctl_lds,
    output logic           ctl_fc,
    output logic           ctl_sw,
    output logic           n_upd,
    output logic           r_upd,
    output logic           frame_err
);

    localparam int WORD_W = A_W + B_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    logic [2:0]        pins_sync;
    logic              clk_s;
    logic              dat_s;
    logic              le_s;
    logic              clk_prev_q;
    logic              le_prev_q;
    logic              clk_rise;
    logic              le_rise;
    logic              shift_en;
    logic              cnt_clr;
    logic [WORD_W-1:0] word;
    logic              full;
    logic [CTL_W-1:0]  ctl_q;
    sdp_state_t        state;

    sdp_sync #(.LINES(3)) u_sync (
        .clk     (sys_clk),
        .rst_n   (rst_n),
        .d_async ({ser_le, ser_dat, ser_clk}),
        .d_sync  (pins_sync)
    );

    assign clk_s = pins_sync[0];
    assign dat_s = pins_sync[1];
    assign le_s  = pins_sync[2];

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev_q <= 1'b0;
            le_prev_q  <= 1'b0;
        end else begin
            clk_prev_q <= clk_s;
            le_prev_q  <= le_s;
        end
    end

    assign clk_rise = clk_s & ~clk_prev_q;
    assign le_rise  = le_s & ~le_prev_q;
    assign shift_en = (state == ST_COLLECT) && clk_rise && !le_s;
    assign cnt_clr  = (state == ST_DECIDE);

    sdp_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk      (sys_clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (dat_s),
        .cnt_clr  (cnt_clr),
        .word     (word),
        .full     (full)
    );

    sdp_fsm #(
        .A_W    (A_W),
        .B_W    (B_W),
        .CTL_W  (CTL_W),
        .R_W    (R_W),
        .R_MIN  (R_MIN),
        .WORD_W (WORD_W)
    ) u_fsm (
        .clk     (sys_clk),
        .rst_n   (rst_n),
        .le_rise (le_rise),
        .le_lvl  (le_s),
        .word    (word),
        .full    (full),
        .state   (state),
        .a_q     (div_a),
        .b_q     (div_b),
        .ctl_q   (ctl_q),
        .r_q     (ref_div),
        .n_stb   (n_upd),
        .r_stb   (r_upd),
        .ferr_q  (frame_err)
    );

    assign ctl_cs  = ctl_q[CTL_W-1];
    assign ctl_lds = ctl_q[CTL_W-2];
    assign ctl_fc  = ctl_q[CTL_W-3];
    assign ctl_sw  = ctl_q[CTL_W-4];

endmodule

// File: rtl/sdp_chk.sv
module sdp_chk #(
    parameter int A_W   = 7,
    parameter int B_W   = 11,
    parameter int R_W   = 14,
    parameter int R_MIN = 3
) (
    input logic           sys_clk,
    input logic           rst_n,
    input logic [A_W-1:0] div_a,
    input logic [B_W-1:0] div_b,
    input logic [R_W-1:0] ref_div,
    input logic [3:0]     ctl,
    input logic           n_upd,
    input logic           r_upd,
    input logic           frame_err
);

    // R4
    strobe_excl_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !(n_upd && r_upd));

    // R4
    n_pulse_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        n_upd |=> !n_upd);

    // R4
    r_pulse_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        r_upd |=> !r_upd);

    // R4
    n_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !n_upd |-> $stable({div_a, div_b}));

    // R5
    r_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !r_upd |-> $stable({ref_div, ctl}));

    // R6
    r_floor_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ref_div >= R_W'(R_MIN));

    // R7
    ferr_quiet_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $rose(frame_err) |-> !(n_upd || r_upd));

endmodule

bind serial_div_prog sdp_chk #(
    .A_W   (A_W),
    .B_W   (B_W),
    .R_W   (R_W),
    .R_MIN (R_MIN)
) chk_i (
    .sys_clk   (sys_clk),
    .rst_n     (rst_n),
    .div_a     (div_a),
    .div_b     (div_b),
    .ref_div   (ref_div),
    .ctl       ({ctl_cs, ctl_lds, ctl_fc, ctl_sw}),
    .n_upd     (n_upd),
    .r_upd     (r_upd),
    .frame_err (frame_err)
);

// File: tb/serial_div_prog_tb_top.sv
module serial_div_prog_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    typedef struct {
        logic        is_ref;
        logic [18:0] w;
    } exp_t;

    logic        sys_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_le  = 1'b0;
    logic [6:0]  div_a;
    logic [10:0] div_b;
    logic [13:0] ref_div;
    logic        ctl_cs, ctl_lds, ctl_fc, ctl_sw;
    logic        n_upd, r_upd, frame_err;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    // Model of the latch contents, updated when an accepted word is queued.
    logic [6:0]  m_a   = '0;
    logic [10:0] m_b   = '0;
    logic [13:0] m_r   = 14'd3;
    logic [3:0]  m_ctl = '0;

    always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

    serial_div_prog dut_i (
        .sys_clk   (sys_clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .ser_le    (ser_le),
        .div_a     (div_a),
        .div_b     (div_b),
        .ref_div   (ref_div),
        .ctl_cs    (ctl_cs),
        .ctl_lds   (ctl_lds),
        .ctl_fc    (ctl_fc),
        .ctl_sw    (ctl_sw),
        .n_upd     (n_upd),
        .r_upd     (r_upd),
        .frame_err (frame_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [18:0] mk_n(input logic [10:0] b, input logic [6:0] a);
        return {b, a, 1'b0};
    endfunction

    function automatic logic [18:0] mk_r(input logic [3:0] c, input logic [13:0] r);
        return {c, r, 1'b1};
    endfunction

    // Scoreboard monitor: compares latch contents on every strobe.
    always @(negedge sys_clk) begin
        if (rst_n && (n_upd || r_upd)) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R4", "unexpected strobe", {n_upd, r_upd}, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (!e.is_ref) begin
                    check(n_upd && !r_upd, "R4", "strobe kind", {n_upd, r_upd}, 2);
                    check(div_b == e.w[18:8], "R2", "div_b", div_b, e.w[18:8]);
                    check(div_a == e.w[7:1], "R2", "div_a", div_a, e.w[7:1]);
                end else begin
                    check(r_upd && !n_upd, "R4", "strobe kind", {n_upd, r_upd}, 1);
                    check({ctl_cs, ctl_lds, ctl_fc, ctl_sw} == e.w[18:15], "R3",
                          "ctl", {ctl_cs, ctl_lds, ctl_fc, ctl_sw}, e.w[18:15]);
                    check(ref_div == e.w[14:1], "R3", "ref_div", ref_div, e.w[14:1]);
                end
            end
        end
    end

    task automatic shift_bits(input logic [31:0] val, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge sys_clk);
            ser_dat = val[i];
            repeat (HALF_BIT) @(negedge sys_clk);
            ser_clk = 1'b1;
            repeat (HALF_BIT) @(negedge sys_clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic pulse_le();
        @(negedge sys_clk);
        ser_le = 1'b1;
        repeat (8) @(negedge sys_clk);
        ser_le = 1'b0;
        repeat (8) @(negedge sys_clk);
    endtask

    // Driver: shifts a full word and queues the expected result.
    task automatic send_word(input logic [18:0] w, input bit accept);
        if (accept) begin
            exp_t e;
            e.is_ref = w[0];
            e.w      = w;
            sb_q.push_back(e);
            if (w[0]) begin
                m_ctl = w[18:15];
                m_r   = w[14:1];
            end else begin
                m_b = w[18:8];
                m_a = w[7:1];
            end
        end
        shift_bits({13'd0, w}, 19);
        pulse_le();
    endtask

    task automatic check_model(input string req);
        check(sb_q.size() == 0, req, "pending results", sb_q.size(), 0);
        check(div_a == m_a, req, "div_a held", div_a, m_a);
        check(div_b == m_b, req, "div_b held", div_b, m_b);
        check(ref_div == m_r, req, "ref_div held", ref_div, m_r);
        check({ctl_cs, ctl_lds, ctl_fc, ctl_sw} == m_ctl, req, "ctl held",
              {ctl_cs, ctl_lds, ctl_fc, ctl_sw}, m_ctl);
    endtask

    initial begin
        repeat (3) @(negedge sys_clk);
        rst_n = 1'b1;
        @(negedge sys_clk);

        // R1 reset state
        check(div_a == 0, "R1", "div_a", div_a, 0);
        check(div_b == 0, "R1", "div_b", div_b, 0);
        check(ref_div == 3, "R1", "ref_div", ref_div, 3);
        check({ctl_cs, ctl_lds, ctl_fc, ctl_sw} == 0, "R1", "ctl",
              {ctl_cs, ctl_lds, ctl_fc, ctl_sw}, 0);
        check({n_upd, r_upd, frame_err} == 0, "R1", "strobes", {n_upd, r_upd, frame_err}, 0);

        // R2 feedback word; R4 reference latch untouched
        send_word(mk_n(11'h5A3, 7'h2B), 1'b1);
        check_model("R2");

        // R3 reference word; R4 feedback latch untouched
        send_word(mk_r(4'b1010, 14'd1000), 1'b1);
        check_model("R3");
        send_word(mk_n(11'h000, 7'h7F), 1'b1);
        check_model("R4");

        // R6 boundary values
        send_word(mk_r(4'b0000, 14'd3), 1'b1);
        check_model("R6");
        send_word(mk_r(4'b1111, 14'd16383), 1'b1);
        check_model("R6");

        // R5 illegal reference values
        send_word(mk_r(4'b0101, 14'd2), 1'b0);
        check_model("R5");
        send_word(mk_r(4'b0000, 14'd0), 1'b0);
        check_model("R5");

        // R7 short word
        shift_bits(32'h2AB, 10);
        pulse_le();
        check(frame_err == 1'b1, "R7", "frame_err set", frame_err, 1);
        check_model("R7");
        send_word(mk_n(11'h123, 7'h45), 1'b1);
        check(frame_err == 1'b0, "R7", "frame_err cleared", frame_err, 0);
        check_model("R7");

        // R8 overlong word: three leading bits fall out
        begin
            logic [18:0] w;
            exp_t e;
            w = mk_n(11'h7FE, 7'h01);
            e.is_ref = 1'b0;
            e.w      = w;
            sb_q.push_back(e);
            m_b = w[18:8];
            m_a = w[7:1];
            shift_bits({10'd0, 3'b101, w}, 22);
            pulse_le();
            check_model("R8");
        end

        // R9 shift-clock edges while the load strobe is high are not counted
        @(negedge sys_clk);
        ser_le = 1'b1;
        repeat (8) @(negedge sys_clk);
        shift_bits(32'h1F, 5);
        @(negedge sys_clk);
        ser_le = 1'b0;
        repeat (8) @(negedge sys_clk);
        shift_bits(32'h3FFE, 14);
        pulse_le();
        check(frame_err == 1'b1, "R9", "short after le-high edges", frame_err, 1);
        check_model("R9");

        // R10 latency from the load-strobe pin to the strobe
        begin
            logic [18:0] w;
            exp_t e;
            w = mk_n(11'h2C7, 7'h33);
            e.is_ref = 1'b0;
            e.w      = w;
            sb_q.push_back(e);
            m_b = w[18:8];
            m_a = w[7:1];
            shift_bits({13'd0, w}, 19);
            @(negedge sys_clk);
            ser_le = 1'b1;
            repeat (3) @(negedge sys_clk);
            check(n_upd == 1'b0, "R10", "strobe early", n_upd, 0);
            @(negedge sys_clk);
            check(n_upd == 1'b1, "R10", "strobe on fourth edge", n_upd, 1);
            @(negedge sys_clk);
            check(n_upd == 1'b0, "R4", "strobe width", n_upd, 0);
            repeat (6) @(negedge sys_clk);
            ser_le = 1'b0;
            repeat (8) @(negedge sys_clk);
            check(frame_err == 1'b0, "R10", "frame_err cleared", frame_err, 0);
            check_model("R10");
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge sys_clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "R1", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule